// File: doc/BRIEF.md
# Bit-Reversed Vector Load Address Generator

The block sequences a vector floating-point load one element at a time. A start pulse captures the vector length, the base register value, a flag that marks the base register field as zero, an 11-bit signed displacement, a shift-control register value, the element size and an update-mode flag. From the following cycle the block offers one element per handshake. Each element carries a destination register index, an effective address, an access size and a flag that asks for a single-to-double widening.

Element indices are permuted by bit reversal over log2(VL) bits. This is the reordering step of a radix-2 FFT, so a single vector load delivers data in butterfly order. The offset of step i is the reversed index times the sign-extended displacement, shifted left by the low six bits of the shift-control value. The offset is added to the base modulo 2^64.

In update mode the register contents are always the base, and the last address issued is handed back for writeback to the base register. Memory access and the float widening itself belong to the units downstream.

Top module: `bitrev_vload_agu`

## Requirements
- R1: Element step i has address base + ((rev(i) * sext64(disp_i)) << n) modulo 2^64. Here n = shctl_i[5:0], the six least significant bits of the shift-control value.
- R2: rev(i) reverses the low log2(VL) bits of i. With VL=4, steps 0,1,2,3 give 0,2,1,3. With VL=1, step 0 gives 0.
- R3: With upd_i=0 and base_zero_i=1, the base is 0. With upd_i=0 and base_zero_i=0, the base is base_i.
- R4: With upd_i=1, the base is base_i whatever the value of base_zero_i.
- R5: With upd_i=1, wb_valid_o is high for exactly one cycle, in the cycle after the last element is accepted, and wb_addr_o then equals that element's address. With upd_i=0, wb_valid_o stays low.
- R6: With dbl_i=0, each element has elem_bytes_o=4 and elem_cvt_o=1. With dbl_i=1, each element has elem_bytes_o=8 and elem_cvt_o=0.
- R7: Element step i has elem_dst_o = (frt_i + i) mod 32.
- R8: A start whose vlen_i is not a power of two in 1..64 raises err_o for one cycle, in the cycle after the start, and issues no element.
- R9: While elem_valid_o=1 and elem_ready_i=0, the element and all its fields hold unchanged in the next cycle.
- R10: The first element is valid in the cycle after an accepted start. done_o pulses for one cycle in the cycle after element VL-1 is accepted. A start_i while a vector is in flight is ignored.
- R11: After reset, elem_valid_o, done_o, err_o and wb_valid_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; taken only while idle |
| vlen_i | input | 7 | Vector length |
| base_i | input | 64 | Base register contents |
| base_zero_i | input | 1 | Base register field is zero |
| disp_i | input | 11 | Signed displacement immediate |
| shctl_i | input | 64 | Shift-control register value |
| dbl_i | input | 1 | 1 selects double precision, 0 selects single |
| upd_i | input | 1 | Update mode (base writeback) |
| frt_i | input | 5 | First destination register |
| elem_valid_o | output | 1 | Element offered |
| elem_ready_i | input | 1 | Consumer accepts the element |
| elem_dst_o | output | 5 | Destination register index |
| elem_addr_o | output | 64 | Effective address |
| elem_bytes_o | output | 4 | Access size in bytes |
| elem_cvt_o | output | 1 | Widen single to double |
| wb_valid_o | output | 1 | Base writeback strobe |
| wb_addr_o | output | 64 | Base writeback value |
| done_o | output | 1 | Vector complete pulse |
| err_o | output | 1 | Invalid vector length pulse |

## Verification
A step counter that skips, repeats or runs past VL-1 shows at once as a wrong address or destination on the very next offered element. It also shows as a done_o pulse that comes early, late or never. A wrong captured length or a wrong log2 width shows as addresses that break the expected permutation, as early as the second element. Every element of every vector is compared with a reference computed in the bench, with and without stalls. The done pulse, the writeback pulse and the error pulse are each checked in the exact cycle the requirements name, so a one-cycle slip shows immediately.

// File: rtl/bvl_pkg.sv
package bvl_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} bvl_state_e;
endpackage

// File: rtl/bvl_vl_decode.sv
module bvl_vl_decode #(
  parameter int LG_MAX = 6,
  localparam int LGW   = $clog2(LG_MAX + 1)
) (
  input  logic [LG_MAX:0]  vl_i,
  output logic             ok_o,
  output logic [LGW-1:0]   lg_o
);
  always_comb begin
    ok_o = 1'b0;
    lg_o = '0;
    for (int j = 0; j <= LG_MAX; j++) begin
      if (vl_i == ((LG_MAX + 1)'(1) << j)) begin
        ok_o = 1'b1;
        lg_o = LGW'(j);
      end
    end
  end
endmodule

// File: rtl/bvl_bitrev.sv
module bvl_bitrev #(
  parameter int LG_MAX = 6,
  localparam int LGW   = $clog2(LG_MAX + 1)
) (
  input  logic [LG_MAX-1:0] step_i,
  input  logic [LGW-1:0]    lg_i,
  output logic [LG_MAX-1:0] rev_o
);
  logic [LG_MAX-1:0] full_rev;
  logic [LGW:0]      drop;

  for (genvar g = 0; g < LG_MAX; g++) begin : g_rev
    assign full_rev[g] = step_i[LG_MAX-1-g];
  end

  // full reversal, then discard the positions above log2(VL)
  assign drop  = (LGW+1)'(LG_MAX) - {1'b0, lg_i};
  assign rev_o = full_rev >> drop;
endmodule

// File: rtl/bvl_ea_gen.sv
module bvl_ea_gen #(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 11,
  parameter int IDX_W  = 6,
  parameter int SH_W   = 6
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] ea_o
);
  logic [ADDR_W-1:0] disp_sx;
  logic [ADDR_W-1:0] prod;

  assign disp_sx = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign prod    = disp_sx * ADDR_W'(idx_i);
  assign ea_o    = base_i + (prod << sh_i);
endmodule

// File: rtl/bitrev_vload_agu.sv
module bitrev_vload_agu
  import bvl_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 11,
  parameter int SH_W   = 6,
  parameter int REG_W  = 5,
  parameter int LG_MAX = 6,
  localparam int LGW   = $clog2(LG_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LG_MAX:0]   vlen_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              base_zero_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] shctl_i,
  input  logic              dbl_i,
  input  logic              upd_i,
  input  logic [REG_W-1:0]  frt_i,
  output logic              elem_valid_o,
  input  logic              elem_ready_i,
  output logic [REG_W-1:0]  elem_dst_o,
  output logic [ADDR_W-1:0] elem_addr_o,
  output logic [3:0]        elem_bytes_o,
  output logic              elem_cvt_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic              done_o,
  output logic              err_o
);
  bvl_state_e        st_q;
  logic [LG_MAX-1:0] step_q;
  logic [LG_MAX:0]   vl_q;
  logic [LGW-1:0]    lg_q;
  logic [ADDR_W-1:0] base_q;
  logic [DISP_W-1:0] disp_q;
  logic [SH_W-1:0]   sh_q;
  logic              dbl_q, upd_q;
  logic [REG_W-1:0]  frt_q;
  logic              done_q, err_q, wbv_q;
  logic [ADDR_W-1:0] wba_q;

  logic              vl_ok;
  logic [LGW-1:0]    vl_lg;
  logic [LG_MAX-1:0] rev_idx;
  logic [ADDR_W-1:0] ea;
  logic              take, fire, last;

  bvl_vl_decode #(.LG_MAX(LG_MAX)) u_vl (
    .vl_i (vlen_i),
    .ok_o (vl_ok),
    .lg_o (vl_lg)
  );

  bvl_bitrev #(.LG_MAX(LG_MAX)) u_rev (
    .step_i (step_q),
    .lg_i   (lg_q),
    .rev_o  (rev_idx)
  );

  bvl_ea_gen #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .IDX_W  (LG_MAX),
    .SH_W   (SH_W)
  ) u_ea (
    .base_i (base_q),
    .disp_i (disp_q),
    .sh_i   (sh_q),
    .idx_i  (rev_idx),
    .ea_o   (ea)
  );

  assign take = (st_q == ST_IDLE) && start_i;
  assign fire = elem_valid_o && elem_ready_i;
  assign last = ({1'b0, step_q} == (vl_q - (LG_MAX+1)'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      vl_q   <= '0;
      lg_q   <= '0;
      base_q <= '0;
      disp_q <= '0;
      sh_q   <= '0;
      dbl_q  <= 1'b0;
      upd_q  <= 1'b0;
      frt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      wbv_q  <= 1'b0;
      wba_q  <= '0;
    end else begin
      done_q <= fire && last;
      wbv_q  <= fire && last && upd_q;
      err_q  <= take && !vl_ok;
      if (fire && last) wba_q <= ea;
      if (take && vl_ok) begin
        st_q   <= ST_RUN;
        step_q <= '0;
        vl_q   <= vlen_i;
        lg_q   <= vl_lg;
        // update form always uses the register; plain form honours a zero field
        base_q <= (base_zero_i && !upd_i) ? '0 : base_i;
        disp_q <= disp_i;
        sh_q   <= shctl_i[SH_W-1:0];
        dbl_q  <= dbl_i;
        upd_q  <= upd_i;
        frt_q  <= frt_i;
      end else if (fire) begin
        if (last) st_q <= ST_IDLE;
        else      step_q <= step_q + LG_MAX'(1);
      end
    end
  end

  assign elem_valid_o = (st_q == ST_RUN);
  assign elem_addr_o  = ea;
  assign elem_dst_o   = frt_q + REG_W'(step_q);
  assign elem_bytes_o = dbl_q ? 4'd8 : 4'd4;
  assign elem_cvt_o   = !dbl_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign wb_valid_o   = wbv_q;
  assign wb_addr_o    = wba_q;

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_valid_o && !elem_ready_i |=> elem_valid_o && $stable(elem_addr_o) && $stable(elem_dst_o)); // R9
  AST_DONE_FOLLOWS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(fire)); // R10
  AST_ERR_NO_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !elem_valid_o); // R8
  AST_WB_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o); // R5
  AST_WB_ADDR_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> wb_addr_o == $past(elem_addr_o)); // R5
  AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_valid_o |-> ({1'b0, step_q} < vl_q)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
endmodule

// File: tb/bitrev_vload_agu_bench.sv
module bitrev_vload_agu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [6:0]  vl;
    logic [63:0] base;
    logic        bz;
    logic [10:0] disp;
    logic [63:0] shctl;
    logic        dbl;
    logic        upd;
    logic [4:0]  frt;
    logic        stall;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{7'd4,  64'h10,                  1'b0, 11'd4,     64'h2,                  1'b0, 1'b0, 5'd12, 1'b0},
    '{7'd8,  64'h1000,                1'b1, 11'h7FD,   64'hFFFF_FFFF_FFFF_FFC3, 1'b1, 1'b0, 5'd30, 1'b1},
    '{7'd1,  64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 11'h3FF,   64'h3F,                 1'b0, 1'b1, 5'd0,  1'b0},
    '{7'd64, 64'h8000,                1'b1, 11'h400,   64'h0,                  1'b1, 1'b1, 5'd5,  1'b0},
    '{7'd16, 64'hFFFF_FFFF_FFFF_FF00, 1'b0, 11'd1,     64'h3C,                 1'b0, 1'b1, 5'd31, 1'b1},
    '{7'd2,  64'h55,                  1'b1, 11'd7,     64'h1,                  1'b0, 1'b0, 5'd3,  1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  vlen_i = '0;
  logic [63:0] base_i = '0;
  logic        base_zero_i = 1'b0;
  logic [10:0] disp_i = '0;
  logic [63:0] shctl_i = '0;
  logic        dbl_i = 1'b0;
  logic        upd_i = 1'b0;
  logic [4:0]  frt_i = '0;
  logic        elem_valid_o;
  logic        elem_ready_i = 1'b0;
  logic [4:0]  elem_dst_o;
  logic [63:0] elem_addr_o;
  logic [3:0]  elem_bytes_o;
  logic        elem_cvt_o;
  logic        wb_valid_o;
  logic [63:0] wb_addr_o;
  logic        done_o;
  logic        err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bitrev_vload_agu u_bitrev_vload_agu (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_addr(input vec_t v, input int i);
    int k;
    logic [63:0] rev, b, d;
    k = 0;
    for (int j = 0; j < 7; j++) if (v.vl == (7'd1 << j)) k = j;
    rev = '0;
    for (int j = 0; j < k; j++) rev[k-1-j] = i[j];
    b = v.upd ? v.base : (v.bz ? 64'd0 : v.base);
    d = {{53{v.disp[10]}}, v.disp};
    return b + ((rev * d) << v.shctl[5:0]);
  endfunction

  task automatic drive_start(input vec_t v);
    start_i = 1'b1; vlen_i = v.vl; base_i = v.base; base_zero_i = v.bz;
    disp_i = v.disp; shctl_i = v.shctl; dbl_i = v.dbl; upd_i = v.upd; frt_i = v.frt;
  endtask

  task automatic run_vec(input vec_t v);
    logic [63:0] ea, last_ea;
    last_ea = '0;
    @(negedge clk_i);
    drive_start(v);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < int'(v.vl); i++) begin
      ea = ref_addr(v, i);
      if (v.stall) begin
        elem_ready_i = 1'b0;
        @(negedge clk_i);
        chk(elem_valid_o && elem_addr_o == ea, "R9 hold under stall", elem_addr_o, ea);
      end
      elem_ready_i = 1'b1;
      chk(elem_valid_o, "R10 element valid", 64'(elem_valid_o), 64'd1);
      chk(elem_addr_o == ea, "R1 R2 R3 R4 address", elem_addr_o, ea);
      chk(elem_dst_o == 5'(v.frt + 5'(i)), "R7 destination", 64'(elem_dst_o), 64'(5'(v.frt + 5'(i))));
      chk(elem_bytes_o == (v.dbl ? 4'd8 : 4'd4) && elem_cvt_o == !v.dbl, "R6 size/convert",
          {elem_bytes_o, 3'b0, elem_cvt_o}, {(v.dbl ? 4'd8 : 4'd4), 3'b0, !v.dbl});
      chk(!done_o, "R10 no early done", 64'(done_o), 64'd0);
      last_ea = ea;
      @(negedge clk_i);
    end
    elem_ready_i = 1'b0;
    chk(done_o && !elem_valid_o, "R10 done pulse", {done_o, elem_valid_o}, 64'b10);
    chk(wb_valid_o == v.upd, "R5 writeback strobe", 64'(wb_valid_o), 64'(v.upd));
    if (v.upd) chk(wb_addr_o == last_ea, "R5 writeback address", wb_addr_o, last_ea);
    @(negedge clk_i);
    chk(!done_o && !wb_valid_o, "R5 R10 single pulse", {done_o, wb_valid_o}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk_i);
    chk(!elem_valid_o && !done_o && !err_o && !wb_valid_o, "R11 reset state",
        {elem_valid_o, done_o, err_o, wb_valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!elem_valid_o && !done_o && !err_o && !wb_valid_o, "R11 idle after reset",
        {elem_valid_o, done_o, err_o, wb_valid_o}, 64'd0);

    for (int n = 0; n < NVEC; n++) run_vec(VECS[n]);

    // R8: invalid lengths
    foreach (VECS[n]) begin end
    for (int t = 0; t < 3; t++) begin
      v = VECS[0];
      v.vl = (t == 0) ? 7'd3 : (t == 1) ? 7'd0 : 7'd65;
      @(negedge clk_i);
      drive_start(v);
      @(negedge clk_i);
      start_i = 1'b0;
      chk(err_o && !elem_valid_o, "R8 bad length error", {err_o, elem_valid_o}, 64'b10);
      @(negedge clk_i);
      chk(!err_o && !elem_valid_o, "R8 no element issued", {err_o, elem_valid_o}, 64'd0);
    end

    // R10: start while busy is ignored
    v = VECS[5];
    @(negedge clk_i);
    drive_start(v);
    @(negedge clk_i);
    vlen_i = 7'd3; frt_i = 5'd20; // would error if taken
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!err_o && elem_valid_o && elem_dst_o == v.frt, "R10 start ignored while busy",
        {err_o, elem_valid_o, 3'b0, elem_dst_o}, {1'b0, 1'b1, 3'b0, v.frt});
    elem_ready_i = 1'b1;
    chk(elem_addr_o == ref_addr(v, 0), "R10 sequence intact", elem_addr_o, ref_addr(v, 0));
    @(negedge clk_i);
    chk(elem_addr_o == ref_addr(v, 1) && elem_dst_o == 5'(v.frt + 5'd1), "R10 second element",
        elem_addr_o, ref_addr(v, 1));
    @(negedge clk_i);
    elem_ready_i = 1'b0;
    chk(done_o && !err_o, "R10 done after ignored start", {done_o, err_o}, 64'b10);
    @(negedge clk_i);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule